// File: doc/BRIEF.md
# Masked Search Content-Addressable Memory

This block is a synchronous content-addressable memory with 512 words of 64 bits. Software-visible state is held in four places: the word array, one validity flag per word, a 64-bit search key register and a 64-bit bit-enable mask. A single 3-bit command input, sampled on each rising clock edge, selects the operation for that cycle.

Words are written and read directly by address. A search compares the key against every valid word at once. Bit positions cleared in the mask are ignored. The lowest-numbered matching word is reported as a registered hit flag and index.

Validity flags are cleared one at a time or all together. This allows stale entries to be removed without rewriting them.

Top module: `cam_search_array`

## Requirements
- R1: Command code 1 (write) stores `wdata` into the word at `addr` and marks that word valid. Command code 2 (read) places the stored word on `rdata` one cycle later, whether the word is valid or not.
- R2: A word whose validity flag is clear never produces a hit. After reset every validity flag is clear.
- R3: Command code 3 (search) matches a valid word when every bit position whose mask bit is 1 holds the same value in the word and in the key. Positions whose mask bit is 0 always count as equal.
- R4: When several valid words match, the reported index is the lowest matching address.
- R5: The search outcome appears on `hit` and `hit_idx` one cycle after the search command. When nothing matches, `hit` is 0 and `hit_idx` is 0.
- R6: `hit` and `hit_idx` change only after a search command, and `rdata` changes only after a read command. All three are 0 after reset.
- R7: Command code 4 (invalidate) clears the validity flag at `addr`. Command code 5 (flush) clears all validity flags in one cycle.
- R8: Command code 6 loads `wdata` into the mask, and command code 7 loads `wdata` into the key. Both hold their values until reloaded. Reset sets the mask to all ones and the key to zero.
- R9: Command code 0 is idle and changes no state. A search uses the contents, flags, key and mask as they stood before its own clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Operation code for this cycle |
| addr | input | 9 | Word address for write, read and invalidate |
| wdata | input | 64 | Write data, or the value to load into the mask or key |
| rdata | output | 64 | Word returned by the most recent read |
| hit | output | 1 | Most recent search found a valid match |
| hit_idx | output | 9 | Lowest matching address of the most recent search, 0 on a miss |

## Verification
Every command takes effect at the clock edge that samples it. Read data, hit and index are due exactly one edge later, and they must then stay unchanged until the next read or search. The bench drives each command half a cycle before an edge and advances its behavioural model at that edge. It then compares all three outputs two nanoseconds after the edge. Because the comparison runs on every cycle, idle, load and maintenance commands are also checked, and any output that moves when it should not is caught.

// File: rtl/cam_search_array.sv
module cam_search_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_idx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] OP_WRITE  = 3'd1;
  localparam logic [2:0] OP_READ   = 3'd2;
  localparam logic [2:0] OP_SEARCH = 3'd3;
  localparam logic [2:0] OP_INVAL  = 3'd4;
  localparam logic [2:0] OP_FLUSH  = 3'd5;
  localparam logic [2:0] OP_MASK   = 3'd6;
  localparam logic [2:0] OP_KEY    = 3'd7;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  match_line;
  logic [DATA_W-1:0] mask_q, key_q;
  logic [ADDR_W-1:0] first_idx;
  logic              any_match;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match_line[i] = valid_q[i] && (((mem[i] ^ key_q) & mask_q) == '0);
  end

  always_comb begin
    first_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match_line[i]) first_idx = ADDR_W'(i);
  end

  assign any_match = |match_line;

  always_ff @(posedge clk)
    if (cmd == OP_WRITE) mem[addr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      case (cmd)
        OP_WRITE: valid_q[addr] <= 1'b1;
        OP_INVAL: valid_q[addr] <= 1'b0;
        OP_FLUSH: valid_q       <= '0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      key_q  <= '0;
    end else begin
      if (cmd == OP_MASK) mask_q <= wdata;
      if (cmd == OP_KEY)  key_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      if (cmd == OP_READ) rdata <= mem[addr];
      if (cmd == OP_SEARCH) begin
        hit     <= any_match;
        hit_idx <= any_match ? first_idx : '0;
      end
    end
  end
endmodule

// File: rtl/cam_search_array_chk.sv
module cam_search_array_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              hit,
  input logic [ADDR_W-1:0] hit_idx,
  input logic [(1<<ADDR_W)-1:0] valid_q
);
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n) cmd == 3'd1 |=> valid_q[$past(addr)]); // R1
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) (cmd == 3'd3 && valid_q == '0) |=> !hit); // R2
  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> hit_idx == '0); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) cmd != 3'd3 |=> ($stable(hit) && $stable(hit_idx))); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) cmd != 3'd2 |=> $stable(rdata)); // R6
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cmd == 3'd4 |=> !valid_q[$past(addr)]); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cmd == 3'd5 |=> valid_q == '0); // R7
  AST_IDLE_VALID_STABLE: assert property (@(posedge clk) disable iff (!rst_n) cmd == 3'd0 |=> $stable(valid_q)); // R9
endmodule

bind cam_search_array cam_search_array_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .rdata(rdata),
  .hit(hit), .hit_idx(hit_idx), .valid_q(valid_q)
);

// File: tb/cam_search_array_tb.sv
module cam_search_array_tb;
  localparam int AW = 9;
  localparam int DW = 64;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic hit;
  logic [AW-1:0] hit_idx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [DW-1:0] m_mem [N];
  bit            m_val [N];
  logic [DW-1:0] m_mask = '1, m_key = '0, m_rd = '0;
  bit            m_hit = 0;
  int            m_idx = 0;

  cam_search_array #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hit(hit), .hit_idx(hit_idx)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic compare(string tag);
    checks++;
    if (rdata !== m_rd || hit !== m_hit || hit_idx !== AW'(m_idx)) begin
      errors++;
      $display("FAIL %s: actual rdata=%h hit=%b idx=%0d expected rdata=%h hit=%b idx=%0d",
               tag, rdata, hit, hit_idx, m_rd, m_hit, m_idx);
    end
  endtask

  task automatic step(input logic [2:0] c, input int a, input logic [DW-1:0] d, input string tag);
    bit f = 0;
    int fi = 0;
    @(negedge clk);
    cmd = c; addr = AW'(a); wdata = d;
    @(posedge clk);
    if (c == 3'd3) begin
      for (int i = 0; i < N; i++)
        if (!f && m_val[i] && (((m_mem[i] ^ m_key) & m_mask) == '0)) begin f = 1; fi = i; end
      m_hit = f; m_idx = fi;
    end
    if (c == 3'd2) m_rd = m_mem[a];
    if (c == 3'd1) begin m_mem[a] = d; m_val[a] = 1; end
    if (c == 3'd4) m_val[a] = 0;
    if (c == 3'd5) for (int i = 0; i < N; i++) m_val[i] = 0;
    if (c == 3'd6) m_mask = d;
    if (c == 3'd7) m_key = d;
    #2;
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_mem[i] = '0; m_val[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 compare("R6 reset");
    step(3'd3, 0, '0, "R2 search after reset");
    step(3'd1, 0,   64'hDEAD_BEEF_0000_0001, "R1 write 0");
    step(3'd1, 10,  64'h1234_5678_9ABC_DEF0, "R1 write 10");
    step(3'd1, 300, 64'hFFFF_0000_FFFF_0000, "R1 write 300");
    step(3'd1, 511, 64'hA5A5_A5A5_5A5A_5A5A, "R1 write 511");
    step(3'd2, 10, '0, "R1 read 10");
    step(3'd2, 511, '0, "R1 read 511");
    step(3'd0, 0, '0, "R9 idle hold");
    step(3'd7, 0, 64'h1234_5678_9ABC_DEF0, "R8 load key");
    step(3'd3, 0, '0, "R3 exact search");
    step(3'd7, 0, 64'h1234_5678_9ABC_DE00, "R8 load key low byte differs");
    step(3'd3, 0, '0, "R8 reset mask all ones gives miss");
    step(3'd6, 0, 64'hFFFF_FFFF_FFFF_FF00, "R8 load mask");
    step(3'd3, 0, '0, "R3 masked byte ignored");
    step(3'd1, 3,   64'h1234_5678_9ABC_DEAA, "R1 write 3");
    step(3'd1, 400, 64'h1234_5678_9ABC_DE55, "R1 write 400");
    step(3'd3, 0, '0, "R4 lowest index wins");
    step(3'd4, 3, '0, "R7 invalidate 3");
    step(3'd3, 0, '0, "R2 invalid entry skipped");
    step(3'd2, 3, '0, "R1 read invalid word");
    step(3'd6, 0, 64'h0, "R8 mask all off");
    step(3'd3, 0, '0, "R3 empty mask matches entry 0");
    step(3'd4, 0, '0, "R7 invalidate 0");
    step(3'd3, 0, '0, "R4 next lowest valid");
    step(3'd6, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R8 mask all on");
    step(3'd7, 0, 64'hA5A5_A5A5_5A5A_5A5A, "R8 key top entry");
    step(3'd3, 0, '0, "R3 top address hit");
    step(3'd1, 511, 64'h0, "R9 search sees old state");
    step(3'd3, 0, '0, "R5 miss after overwrite");
    step(3'd7, 0, 64'h0, "R8 key zero");
    step(3'd3, 0, '0, "R3 hit on rewritten 511");
    step(3'd5, 0, '0, "R7 flush");
    step(3'd3, 0, '0, "R7 miss after flush");
    step(3'd2, 300, '0, "R1 read after flush");
    for (int k = 0; k < 20; k++) begin
      step(3'd1, k * 25, {32'(k), 32'hC0DE_0000}, "R1 sweep write");
      step(3'd7, 0, {32'(k), 32'hC0DE_0000}, "R8 sweep key");
      step(3'd3, 0, '0, "R3 sweep search");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule